// File: doc/BRIEF.md
# Script Fetch and Dispatch Sequencer

This block runs a chain of two-word instructions held in main memory. It does this for a bus-master I/O engine, with no host help between steps. The host loads a start address with one register write. From then on the sequencer works on its own:

- It arbitrates for the memory bus.
- It reads the instruction at the pointer.
- It decodes the top byte of the first word.
- For a transfer instruction, it passes a byte count and a memory address to the data mover. Both are carried inside the instruction.

When the mover reports completion, the sequencer fetches the next instruction from the advanced pointer. A stop instruction, an unknown opcode or any reported error halts the chain. A halt raises an interrupt to the host, with a code that tells a clean stop apart from a failure.

The read-request, read-beat and mover-launch paths are valid/ready channels. A transfer takes place on any cycle in which both sides are high. The sender holds valid and its payload steady until ready is seen. The read-beat channel drops ready when no beat is expected. Arbitration (`bus_req`/`bus_gnt`), the mover's completion pulses, the host write port and the interrupt outputs are plain level or pulse signals.

Top module: `script_chain_seq`

## Requirements
- R1: With the block idle or halted, a host write with `hw_sel`=0 loads the pointer from `hw_data` and starts a run. `bus_req` is high two cycles after the write is captured, and the first read request carries the written address.
- R2: Each instruction is fetched by one read request at the pointer, followed by two accepted beats: word 0 at the pointer and word 1 four bytes above it. Bits 31:24 of word 0 hold the opcode.
- R3: A read request is presented only while `bus_req` and `bus_gnt` are both high. `bus_req` stays high from arbitration until the second beat is taken. An unaccepted request keeps its address.
- R4: Opcode 0x10 is a transfer. The mover launch carries `mv_count` = word 0 bits 23:0 and `mv_addr` = word 1. Count and address stay steady while `mv_ready` is low.
- R5: While the mover works, `bus_req` is low. After `mv_done`, `bus_req` drops for at least one cycle before the next fetch. The next fetch address is the previous fetch address plus 8.
- R6: Opcode 0xF0 halts the chain and sets `irq`=1 with `irq_code`=1. While halted, `bus_req`, `rd_beat_ready` and `mv_valid` stay low and `irq` stays high.
- R7: An opcode other than 0x10 or 0xF0 is an error, and so is an error flag on a read beat or an `mv_err` pulse. Each halts the chain with `irq`=1 and `irq_code`=2 (0 means no halt). No further fetch follows.
- R8: While halted, a write with `hw_sel`=1 and `hw_data` bit 0 = 1 clears `irq`/`irq_code` and returns to idle. The same write with bit 0 = 0 changes nothing. A pointer write while halted clears `irq` and restarts at the new address.
- R9: A transfer instruction with a zero count makes no mover launch. The next instruction is fetched at pointer plus 8.
- R10: Pointer writes while a run is in progress are ignored, and the fetch sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Host register write strobe |
| hw_sel | input | 1 | 0 = pointer, 1 = status clear |
| hw_data | input | ADDR_W | Host write data |
| bus_req | output | 1 | Memory bus request |
| bus_gnt | input | 1 | Memory bus grant |
| rd_req_valid | output | 1 | Two-beat read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | ADDR_W | Read start address |
| rd_beat_valid | input | 1 | Read data beat valid |
| rd_beat_ready | output | 1 | Sequencer takes a beat |
| rd_beat_data | input | 32 | Read data word |
| rd_beat_err | input | 1 | Beat carries a bus error |
| mv_valid | output | 1 | Mover launch valid |
| mv_ready | input | 1 | Mover accepts launch |
| mv_count | output | CNT_W | Byte count to move |
| mv_addr | output | ADDR_W | Memory start address for the move |
| mv_done | input | 1 | Mover finished (pulse) |
| mv_err | input | 1 | Mover failed (pulse) |
| irq | output | 1 | Host interrupt, high while halted |
| irq_code | output | 2 | Halt cause: 1 stop opcode, 2 error |

## Verification
The hardest case to reach is a pointer write that lands while a run is in flight: it must change nothing. Chains end so quickly that a write at a random time would often restart a halted block instead. The stimulus therefore waits until a mover launch is visible on the ports and writes at that moment, while the chain is provably busy. Halts on a read-beat error or a mover error are forced by tagging one fetch address or one launch index in the bench's memory and mover models. Random grant, ready and beat stalls cover the hold rules of every channel.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int WORD_W = 32;
  localparam int OPC_W  = 8;
  localparam logic [OPC_W-1:0] OPC_XFER = 8'h10;
  localparam logic [OPC_W-1:0] OPC_STOP = 8'hF0;

  typedef enum logic [1:0] {
    OPK_XFER,
    OPK_STOP,
    OPK_BAD
  } op_kind_e;

  typedef enum logic [1:0] {
    HC_NONE = 2'd0,
    HC_STOP = 2'd1,
    HC_ERR  = 2'd2
  } halt_code_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_FETCH,
    S_LAUNCH,
    S_MOVE,
    S_HALT
  } seq_state_e;

  function automatic op_kind_e classify(input logic [OPC_W-1:0] opc);
    case (opc)
      OPC_XFER: classify = OPK_XFER;
      OPC_STOP: classify = OPK_STOP;
      default:  classify = OPK_BAD;
    endcase
  endfunction
endpackage

// File: rtl/seq_fetch.sv
module seq_fetch
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int NBEAT  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [ADDR_W-1:0]       base,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output logic                    rd_req_valid,
  input  logic                    rd_req_ready,
  output logic [ADDR_W-1:0]       rd_req_addr,
  input  logic                    rd_beat_valid,
  output logic                    rd_beat_ready,
  input  logic [WORD_W-1:0]       rd_beat_data,
  input  logic                    rd_beat_err,
  output logic                    done,
  output logic                    fail,
  output logic [NBEAT*WORD_W-1:0] words
);
  localparam int BW = (NBEAT > 1) ? $clog2(NBEAT) : 1;

  typedef enum logic [1:0] {F_IDLE, F_ARB, F_ADDR, F_BEAT} fst_e;

  fst_e              st;
  logic [BW-1:0]     beat;
  logic [ADDR_W-1:0] addr_q;
  logic              take;
  logic              last;

  assign take          = (st == F_BEAT) && rd_beat_valid;
  assign last          = (beat == BW'(NBEAT - 1));
  assign bus_req       = (st != F_IDLE);
  assign rd_req_valid  = (st == F_ADDR);
  assign rd_beat_ready = (st == F_BEAT);
  assign rd_req_addr   = addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= F_IDLE;
      beat   <= '0;
      addr_q <= '0;
      done   <= 1'b0;
      fail   <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        F_IDLE: if (start) begin
          addr_q <= base;
          beat   <= '0;
          st     <= F_ARB;
        end
        F_ARB:  if (bus_gnt) st <= F_ADDR;
        F_ADDR: if (rd_req_ready) st <= F_BEAT;
        F_BEAT: if (take) begin
          if (rd_beat_err) begin
            st   <= F_IDLE;
            fail <= 1'b1;
          end else if (last) begin
            st   <= F_IDLE;
            done <= 1'b1;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: st <= F_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < NBEAT; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk) begin
      if (!rst_n) w_q <= '0;
      else if (take && !rd_beat_err && beat == BW'(g)) w_q <= rd_beat_data;
    end
    assign words[g*WORD_W +: WORD_W] = w_q;
  end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  output op_kind_e          kind,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] maddr,
  output logic              count_zero
);
  assign kind       = classify(word0[WORD_W-1 -: OPC_W]);
  assign count      = word0[CNT_W-1:0];
  assign maddr      = word1[ADDR_W-1:0];
  assign count_zero = (count == '0);
endmodule

// File: rtl/script_chain_seq.sv
module script_chain_seq
  import seq_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  input  logic              hw_sel,
  input  logic [ADDR_W-1:0] hw_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_beat_valid,
  output logic              rd_beat_ready,
  input  logic [31:0]       rd_beat_data,
  input  logic              rd_beat_err,
  output logic              mv_valid,
  input  logic              mv_ready,
  output logic [CNT_W-1:0]  mv_count,
  output logic [ADDR_W-1:0] mv_addr,
  input  logic              mv_done,
  input  logic              mv_err,
  output logic              irq,
  output logic [1:0]        irq_code
);
  localparam int FETCH_BEATS = 2;
  localparam int STEP        = FETCH_BEATS * WORD_W / 8;

  seq_state_e                    state;
  halt_code_e                    code_q;
  logic [ADDR_W-1:0]             ptr;
  logic [CNT_W-1:0]              cnt_q;
  logic [ADDR_W-1:0]             maddr_q;
  logic                          f_start, f_done, f_fail;
  logic [FETCH_BEATS*WORD_W-1:0] f_words;
  op_kind_e                      d_kind;
  logic [CNT_W-1:0]              d_count;
  logic [ADDR_W-1:0]             d_maddr;
  logic                          d_zero;
  logic                          ptr_wr, clr_wr;

  assign ptr_wr   = hw_valid && !hw_sel;
  assign clr_wr   = hw_valid && hw_sel && hw_data[0];
  assign f_start  = (state == S_START);
  assign mv_valid = (state == S_LAUNCH);
  assign mv_count = cnt_q;
  assign mv_addr  = maddr_q;
  assign irq      = (state == S_HALT);
  assign irq_code = code_q;

  seq_fetch #(.ADDR_W(ADDR_W), .NBEAT(FETCH_BEATS)) i_fetch (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (f_start),
    .base         (ptr),
    .bus_req      (bus_req),
    .bus_gnt      (bus_gnt),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_beat_valid(rd_beat_valid),
    .rd_beat_ready(rd_beat_ready),
    .rd_beat_data (rd_beat_data),
    .rd_beat_err  (rd_beat_err),
    .done         (f_done),
    .fail         (f_fail),
    .words        (f_words)
  );

  seq_decode #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_decode (
    .word0     (f_words[WORD_W-1:0]),
    .word1     (f_words[2*WORD_W-1:WORD_W]),
    .kind      (d_kind),
    .count     (d_count),
    .maddr     (d_maddr),
    .count_zero(d_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      code_q  <= HC_NONE;
      ptr     <= '0;
      cnt_q   <= '0;
      maddr_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (ptr_wr) begin
          ptr   <= hw_data;
          state <= S_START;
        end
        S_START: state <= S_FETCH;
        S_FETCH: begin
          if (f_fail) begin
            code_q <= HC_ERR;
            state  <= S_HALT;
          end else if (f_done) begin
            ptr <= ptr + ADDR_W'(STEP);
            case (d_kind)
              OPK_XFER: begin
                if (d_zero) begin
                  state <= S_START;
                end else begin
                  cnt_q   <= d_count;
                  maddr_q <= d_maddr;
                  state   <= S_LAUNCH;
                end
              end
              OPK_STOP: begin
                code_q <= HC_STOP;
                state  <= S_HALT;
              end
              default: begin
                code_q <= HC_ERR;
                state  <= S_HALT;
              end
            endcase
          end
        end
        S_LAUNCH: if (mv_ready) state <= S_MOVE;
        S_MOVE: begin
          if (mv_err) begin
            code_q <= HC_ERR;
            state  <= S_HALT;
          end else if (mv_done) begin
            state <= S_START;
          end
        end
        S_HALT: begin
          if (ptr_wr) begin
            ptr    <= hw_data;
            code_q <= HC_NONE;
            state  <= S_START;
          end else if (clr_wr) begin
            code_q <= HC_NONE;
            state  <= S_IDLE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/script_chain_seq_chk.sv
module script_chain_seq_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              rd_beat_ready,
  input logic              mv_valid,
  input logic              mv_ready,
  input logic [CNT_W-1:0]  mv_count,
  input logic [ADDR_W-1:0] mv_addr,
  input logic              irq,
  input logic [1:0]        irq_code
);
  p_req_granted_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> (bus_req && bus_gnt));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  p_launch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_count) && $stable(mv_addr)));

  p_launch_off_bus_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> !bus_req);

  p_launch_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mv_valid |-> (mv_count != '0));

  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!bus_req && !mv_valid && !rd_beat_ready));

  p_halt_coded_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_code != 2'd0));

  p_run_uncoded_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !irq |-> (irq_code == 2'd0));
endmodule

bind script_chain_seq script_chain_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_script_chain_seq.sv
module test_script_chain_seq;
  localparam logic [7:0] T_XFER = 8'h10;
  localparam logic [7:0] T_STOP = 8'hF0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0, hw_sel = 1'b0;
  logic [31:0] hw_data = '0;
  logic        bus_req, bus_gnt;
  logic        rd_req_valid, rd_req_ready;
  logic [31:0] rd_req_addr;
  logic        rd_beat_valid, rd_beat_ready, rd_beat_err;
  logic [31:0] rd_beat_data;
  logic        mv_valid, mv_ready, mv_done, mv_err;
  logic [23:0] mv_count;
  logic [31:0] mv_addr;
  logic        irq;
  logic [1:0]  irq_code;

  always #5 clk = ~clk;

  script_chain_seq i_script_chain_seq (.*);

  int tests = 0, fails = 0;
  logic [31:0] mem [0:63];
  int          exp_cnt [0:7];
  logic [31:0] exp_ma [0:7];
  int n_exp_mv, exp_fetch, exp_code, mv_err_at;
  logic [31:0] run_base, beat_err_addr, beat_addr;
  bit beat_err_en = 0, force_zero = 0, saw_release = 0, busy_in_halt = 0, err_pend = 0;
  int fetch_seen = 0, mv_seen = 0, addr_bad = 0, beats_left = 0, done_wait = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [23:0] pick_count();
    int r = $urandom % 8;
    if (force_zero || r < 2) return 24'h0;
    if (r == 2) return 24'hFFFFFF;
    if (r == 3) return 24'h1;
    return 24'($urandom);
  endfunction

  // memory, arbiter and mover models; drive at falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_gnt = 0; rd_req_ready = 0; rd_beat_valid = 0; rd_beat_err = 0; rd_beat_data = '0;
      mv_ready = 0; mv_done = 0; mv_err = 0; beats_left = 0; done_wait = 0;
    end else begin
      if (!bus_req) saw_release = 1;
      if (irq && bus_req) busy_in_halt = 1;
      bus_gnt = bus_req && (bus_gnt || ($urandom % 3 == 0));
      if (beats_left > 0) begin
        rd_beat_valid = ($urandom % 4 != 0);
        rd_beat_data  = mem[beat_addr[7:2]];
        rd_beat_err   = beat_err_en && (beat_addr == beat_err_addr);
        if (rd_beat_valid && rd_beat_ready) begin
          if (rd_beat_err) beats_left = 0;
          else begin beats_left--; beat_addr += 4; end
        end
      end else begin
        rd_beat_valid = 0; rd_beat_err = 0;
      end
      rd_req_ready = ($urandom % 2 == 0);
      if (rd_req_valid && rd_req_ready) begin
        // R2/R5: fetch address follows base + 8*n
        if (rd_req_addr != run_base + 32'(8 * fetch_seen)) addr_bad++;
        chk(rd_req_addr == run_base + 32'(8 * fetch_seen), "R5", "fetch address",
            rd_req_addr, run_base + 32'(8 * fetch_seen));
        if (fetch_seen > 0) chk(saw_release, "R5", "bus released between fetches", saw_release, 1);
        saw_release = 0;
        fetch_seen++;
        beats_left = 2;
        beat_addr  = rd_req_addr;
      end
      mv_done = 0; mv_err = 0;
      if (done_wait > 0) begin
        done_wait--;
        if (done_wait == 0) begin
          if (err_pend) mv_err = 1; else mv_done = 1;
        end
      end
      mv_ready = ($urandom % 2 == 0);
      if (mv_valid && mv_ready) begin
        if (mv_seen < n_exp_mv) begin
          chk(mv_count == 24'(exp_cnt[mv_seen]), "R4", "move count", mv_count, exp_cnt[mv_seen]);
          chk(mv_addr == exp_ma[mv_seen], "R4", "move address", mv_addr, exp_ma[mv_seen]);
        end else begin
          chk(0, "R9", "unexpected launch", mv_seen, n_exp_mv);
        end
        err_pend = (mv_seen == mv_err_at);
        mv_seen++;
        done_wait = 1 + $urandom % 4;
      end
    end
  end

  // term: 0 stop opcode, 1 bad opcode, 2 read beat error, 3 mover error
  task automatic build(input logic [31:0] base, input int nm, input int term);
    logic [31:0] a, w1;
    logic [23:0] c;
    logic [7:0]  bad;
    n_exp_mv = 0; mv_err_at = -1; beat_err_en = 0;
    for (int i = 0; i < nm; i++) begin
      a = base + 32'(8 * i);
      c = pick_count();
      if (term == 3 && i == nm - 1 && c == 0) c = 24'h1;
      w1 = $urandom;
      mem[a[7:2]]        = {T_XFER, c};
      mem[a[7:2] + 6'd1] = w1;
      if (c != 0) begin exp_cnt[n_exp_mv] = int'(c); exp_ma[n_exp_mv] = w1; n_exp_mv++; end
    end
    a = base + 32'(8 * nm);
    exp_fetch = nm + 1; exp_code = 2;
    case (term)
      0: begin mem[a[7:2]] = {T_STOP, 24'($urandom)}; exp_code = 1; end
      1: begin
        bad = 8'($urandom);
        if (bad == T_XFER || bad == T_STOP) bad = 8'h00;
        mem[a[7:2]] = {bad, 24'($urandom)};
      end
      2: begin mem[a[7:2]] = $urandom; beat_err_en = 1; beat_err_addr = a; end
      default: begin exp_fetch = nm; mv_err_at = n_exp_mv - 1; end
    endcase
    mem[a[7:2] + 6'd1] = $urandom;
  endtask

  task automatic host_wr(input logic sel, input logic [31:0] d);
    @(negedge clk); hw_valid = 1; hw_sel = sel; hw_data = d;
    @(negedge clk); hw_valid = 0;
  endtask

  task automatic run(input logic [31:0] base, input int nm, input int term,
                     input bit poke, input bit clear_after);
    bit was_halt = irq;
    build(base, nm, term);
    run_base = base; fetch_seen = 0; mv_seen = 0; addr_bad = 0;
    host_wr(0, base);
    busy_in_halt = 0;
    if (was_halt) chk(irq == 0 && irq_code == 0, "R8", "pointer write while halted clears irq", irq, 0);
    @(negedge clk);
    chk(bus_req == 1, "R1", "bus request after start", bus_req, 1);
    if (poke) begin
      for (int i = 0; i < 3000; i++) begin
        @(negedge clk);
        if (mv_valid) begin
          hw_valid = 1; hw_sel = 0; hw_data = 32'h300;
          @(negedge clk); hw_valid = 0;
          break;
        end
      end
    end
    for (int i = 0; i < 5000 && !irq; i++) @(negedge clk);
    chk(irq == 1, (exp_code == 1) ? "R6" : "R7", "halt reached", irq, 1);
    chk(irq_code == 2'(exp_code), (exp_code == 1) ? "R6" : "R7", "halt code", irq_code, exp_code);
    chk(fetch_seen == exp_fetch, "R2", "instruction fetch count", fetch_seen, exp_fetch);
    chk(mv_seen == n_exp_mv, "R4", "launch count", mv_seen, n_exp_mv);
    if (poke) chk(addr_bad == 0 && fetch_seen == exp_fetch, "R10", "pointer write ignored mid-run", addr_bad, 0);
    repeat (12) @(negedge clk);
    chk(irq == 1 && !busy_in_halt, "R6", "quiet and sticky while halted", busy_in_halt, 0);
    if (clear_after) begin
      host_wr(1, 32'h0);
      chk(irq == 1, "R8", "status write with bit0=0 ignored", irq, 1);
      host_wr(1, 32'h1);
      chk(irq == 0 && irq_code == 0, "R8", "status clear", irq, 0);
      repeat (3) @(negedge clk);
      chk(bus_req == 0 && irq == 0, "R8", "idle after clear", bus_req, 0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 64; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!irq && !bus_req && !mv_valid && !rd_req_valid && irq_code == 0, "R1",
        "reset state", {irq, bus_req, mv_valid, rd_req_valid}, 0);
    // directed corners
    run(32'h00, 0, 0, 0, 1);                   // R6 stop as first instruction
    force_zero = 1;
    run(32'h40, 4, 0, 0, 1);                   // R9 all zero-count transfers
    chk(mv_seen == 0, "R9", "no launch for zero counts", mv_seen, 0);
    force_zero = 0;
    run(32'h10, 3, 1, 0, 1);                   // R7 unknown opcode
    run(32'h20, 2, 2, 0, 0);                   // R7 read beat error
    run(32'h08, 3, 3, 0, 1);                   // R8 restart from halt, R7 mover error
    run(32'h30, 5, 0, 1, 1);                   // R10 write during launch
    // random chains
    for (int k = 0; k < 14; k++) begin
      int nm = $urandom % 7;
      int term = $urandom % 4;
      if (term == 3 && nm == 0) term = 0;
      run(32'(8 * ($urandom % 16)), nm, term, 0, ($urandom % 2 == 0));
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule